// File: doc/BRIEF.md
# Stale Line Probe Table

This block sits beside one processor's data cache and lets that cache keep serving loads from a line that another processor has invalidated. The invalidation does not simply kill the line. It carries a probe, which is a timer value stamped by the processor that wrote the line. The table stores that probe with the line address. While the probe is still young, a load to the line may use the stale copy and skip the coherence miss.

The table holds one counter per processor and advances each one on its own step strobe. An entry stops being usable in two ways. The first is expiry: the age of its probe, measured against the issuing processor's counter, reaches the lifetime limit. The second is re-observation: a later message carries an upstream probe set whose timer for that processor has caught up with the stored probe. In both cases the entry is released. When every slot is occupied, a new invalidation pushes out the entry that has gone longest without being reallocated, and that line is then truly invalid.

The lookup port is combinational on the registered table state. All table updates take effect at the next clock edge.

Top module: `stale_probe_table`

## Requirements
- R1: After reset no entry is held, every processor counter is 0, and a lookup of any address reports not usable.
- R2: A cycle with `inv_valid_i` high records `inv_addr_i`, `inv_proc_i` and `inv_probe_i`. From the next cycle on, a lookup of that address reports usable until the entry is released.
- R3: A lookup of an address with no valid entry reports not usable, and the load must take a coherence miss.
- R4: An entry is expired when (counter of its processor − stored probe) mod 2^TIMER_W is at least LIFETIME. An expired entry reports not usable in the same cycle and is freed at the next edge, so a later wrap of the counter never makes it usable again.
- R5: Each processor counter starts at 0, increments by one mod 2^TIMER_W on each cycle where its bit of `cnt_adv_i` is high, and otherwise holds. An entry ages only against the counter of the processor recorded in it.
- R6: A cycle with `obs_valid_i` high frees, at the next edge, every entry whose processor's timer in `obs_probes_i` (bits [k*TIMER_W +: TIMER_W] for processor k) is at or after the stored probe. "At or after" means the difference mod 2^TIMER_W is below 2^(TIMER_W−1).
- R7: An observed timer that lies before the stored probe (difference mod 2^TIMER_W of 2^(TIMER_W−1) or more) leaves the entry usable.
- R8: An invalidation for an address the table already holds overwrites that entry's processor and probe in place and uses no second slot.
- R9: When all DEPTH slots are valid, a new address replaces the entry with the largest allocation age. The allocation age counts the invalidations since the entry was written and saturates at 2·DEPTH−1; ties go to the lowest slot. The replaced line then reports not usable.
- R10: While any slot is free, a new address goes into the lowest free slot and no valid entry is displaced.
- R11: When an invalidation and an observation arrive in the same cycle, the observation and the expiry check act on the entries held before the edge. Slot choice also uses the occupancy before the edge. The newly written entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_adv_i | input | NPROC | Per-processor counter step strobes |
| inv_valid_i | input | 1 | Invalidation with probe arrives |
| inv_addr_i | input | ADDR_W | Line address being invalidated |
| inv_proc_i | input | log2(NPROC) | Processor that issued the probe |
| inv_probe_i | input | TIMER_W | Probe timer value |
| obs_valid_i | input | 1 | Upstream probe set arrives on a message |
| obs_probes_i | input | NPROC*TIMER_W | Probe set, processor k in bits [k*TIMER_W +: TIMER_W] |
| lk_addr_i | input | ADDR_W | Stale-read lookup address |
| lk_usable_o | output | 1 | Stale copy of the looked-up line may be read |

## Verification
The bench goes after the modular arithmetic first. It lets a counter run past the lifetime and then wrap all the way around. A design that compared ages without releasing the entry would bring the line back to life. The same happens with an observed timer just behind the stored probe, which a plain unsigned compare would wrongly treat as re-observed. It checks that ageing follows only the issuing processor's counter, that a repeated address overwrites in place instead of leaking a slot, and that eviction picks the oldest entry rather than slot 0 or a free slot. It also sends a same-cycle invalidation and observation where a wrong priority would drop the new entry. Every cycle it sweeps all lookup addresses of a small configuration against an arithmetic model, across directed phases and a long mixed-traffic run.

// File: rtl/spt_pkg.sv
package spt_pkg;

   // How the slot for an incoming invalidation was chosen.
   typedef enum logic [1:0] {
      PICK_HIT    = 2'd0,
      PICK_FREE   = 2'd1,
      PICK_OLDEST = 2'd2
   } pick_e;

endpackage

// File: rtl/spt_counters.sv
module spt_counters #(
   parameter int NPROC   = 4,
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NPROC-1:0]   adv_i,
   output logic [TIMER_W-1:0] cnt_o [NPROC]
);

   for (genvar g = 0; g < NPROC; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_o[g] <= '0;
         end else if (adv_i[g]) begin
            cnt_o[g] <= cnt_o[g] + 1'b1;
         end
      end

      // R5: a strobe advances exactly this counter by one, modulo its width
      p_counter_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
         adv_i[g] |=> cnt_o[g] == TIMER_W'($past(cnt_o[g]) + 1'b1));

      // R5: no strobe, no movement
      p_counter_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !adv_i[g] |=> $stable(cnt_o[g]));
   end

endmodule

// File: rtl/spt_entry.sv
module spt_entry #(
   parameter int  ADDR_W   = 26,
   parameter int  TIMER_W  = 16,
   parameter int  NPROC    = 4,
   parameter int  LIFETIME = 16384,
   parameter int  AGE_W    = 8,
   localparam int PROC_W   = $clog2(NPROC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIMER_W-1:0] cnt_i [NPROC],
   input  logic               obs_valid_i,
   input  logic [TIMER_W-1:0] obs_i [NPROC],
   input  logic               alloc_i,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [PROC_W-1:0]  wr_proc_i,
   input  logic [TIMER_W-1:0] wr_timer_i,
   input  logic [ADDR_W-1:0]  lk_addr_i,
   output logic               valid_o,
   output logic               inv_hit_o,
   output logic               lk_hit_o,
   output logic               usable_o,
   output logic [AGE_W-1:0]   age_o
);

   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   logic               valid_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [PROC_W-1:0]  proc_q;
   logic [TIMER_W-1:0] timer_q;
   logic [AGE_W-1:0]   age_q;

   logic [TIMER_W-1:0] gap_cnt;
   logic [TIMER_W-1:0] gap_obs;
   logic               expired;
   logic               reobserved;

   // Ages against the issuing processor only; subtraction wraps modulo 2^TIMER_W.
   always_comb begin
      gap_cnt    = cnt_i[proc_q] - timer_q;
      gap_obs    = obs_i[proc_q] - timer_q;
      expired    = gap_cnt >= TIMER_W'(LIFETIME);
      reobserved = obs_valid_i && !gap_obs[TIMER_W-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         proc_q  <= '0;
         timer_q <= '0;
         age_q   <= '0;
      end else if (wr_en_i) begin
         valid_q <= 1'b1;
         addr_q  <= wr_addr_i;
         proc_q  <= wr_proc_i;
         timer_q <= wr_timer_i;
         age_q   <= '0;
      end else if (valid_q && (expired || reobserved)) begin
         valid_q <= 1'b0;
      end else if (valid_q && alloc_i && age_q != AGE_MAX) begin
         age_q <= age_q + 1'b1;
      end
   end

   assign valid_o   = valid_q;
   assign inv_hit_o = valid_q && (addr_q == wr_addr_i);
   assign lk_hit_o  = valid_q && (addr_q == lk_addr_i);
   assign usable_o  = lk_hit_o && !expired;
   assign age_o     = age_q;

   // R2: a written slot holds the new line from the next cycle
   p_alloc_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> valid_q && addr_q == $past(wr_addr_i));

   // R4: an expired probe is gone after one edge
   p_expiry_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && expired && !wr_en_i |=> !valid_q);

   // R6: a re-observed probe is gone after one edge
   p_reobs_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && reobserved && !wr_en_i |=> !valid_q);

   // R7: a live, unobserved entry keeps its line and probe
   p_live_entry_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && !expired && !reobserved && !wr_en_i
      |=> valid_q && $stable(timer_q) && $stable(addr_q));

endmodule

// File: rtl/spt_victim.sv
module spt_victim #(
   parameter int  DEPTH = 128,
   parameter int  AGE_W = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_i,
   input  logic [DEPTH-1:0] valid_i,
   input  logic [DEPTH-1:0] hit_i,
   input  logic [AGE_W-1:0] age_i [DEPTH],
   output logic [IDX_W-1:0] sel_o
);
   import spt_pkg::*;

   logic             hit_found;
   logic             free_found;
   logic [IDX_W-1:0] hit_idx;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] old_idx;
   logic [AGE_W-1:0] old_age;
   pick_e            kind;

   always_comb begin
      hit_found  = 1'b0;
      free_found = 1'b0;
      hit_idx    = '0;
      free_idx   = '0;
      old_idx    = '0;
      old_age    = age_i[0];
      for (int i = 0; i < DEPTH; i++) begin
         if (hit_i[i] && !hit_found) begin
            hit_found = 1'b1;
            hit_idx   = IDX_W'(i);
         end
         if (!valid_i[i] && !free_found) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
      end
      // Strict compare keeps the lowest slot on ties.
      for (int i = 1; i < DEPTH; i++) begin
         if (age_i[i] > old_age) begin
            old_age = age_i[i];
            old_idx = IDX_W'(i);
         end
      end
      if (hit_found) begin
         kind = PICK_HIT;
      end else if (free_found) begin
         kind = PICK_FREE;
      end else begin
         kind = PICK_OLDEST;
      end
      case (kind)
         PICK_HIT:  sel_o = hit_idx;
         PICK_FREE: sel_o = free_idx;
         default:   sel_o = old_idx;
      endcase
   end

   // R8: a repeated address lands on its own slot
   p_hit_reused_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i && (|hit_i) |-> hit_i[sel_o]);

   // R10: a free slot is used before anything is displaced
   p_free_before_evict_r10: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i && !(|hit_i) && !(&valid_i) |-> !valid_i[sel_o]);

   // R9: eviction only happens on a full table
   p_evict_only_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i && kind == PICK_OLDEST |-> &valid_i);

endmodule

// File: rtl/stale_probe_table.sv
module stale_probe_table #(
   parameter int  NPROC    = 4,
   parameter int  TIMER_W  = 16,
   parameter int  LIFETIME = 16384,
   parameter int  DEPTH    = 128,
   parameter int  ADDR_W   = 26,
   localparam int PROC_W   = $clog2(NPROC)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPROC-1:0]           cnt_adv_i,
   input  logic                       inv_valid_i,
   input  logic [ADDR_W-1:0]          inv_addr_i,
   input  logic [PROC_W-1:0]          inv_proc_i,
   input  logic [TIMER_W-1:0]         inv_probe_i,
   input  logic                       obs_valid_i,
   input  logic [NPROC*TIMER_W-1:0]   obs_probes_i,
   input  logic [ADDR_W-1:0]          lk_addr_i,
   output logic                       lk_usable_o
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int AGE_W = IDX_W + 1;

   // Elaboration-time parameter checks
   if (NPROC < 2 || (1 << PROC_W) != NPROC) begin : g_bad_nproc
      $error("NPROC must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (TIMER_W < 2 || TIMER_W > 31) begin : g_bad_timer
      $error("TIMER_W must lie in 2..31");
   end
   if (LIFETIME < 1 || LIFETIME >= (1 << (TIMER_W - 1))) begin : g_bad_life
      $error("LIFETIME must be below half the timer range");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   logic [TIMER_W-1:0] cnt     [NPROC];
   logic [TIMER_W-1:0] obs_arr [NPROC];
   logic [AGE_W-1:0]   age_arr [DEPTH];
   logic [DEPTH-1:0]   valid_v;
   logic [DEPTH-1:0]   hit_v;
   logic [DEPTH-1:0]   lkhit_v;
   logic [DEPTH-1:0]   use_v;
   logic [IDX_W-1:0]   sel;

   for (genvar k = 0; k < NPROC; k++) begin : g_unpack
      assign obs_arr[k] = obs_probes_i[k*TIMER_W +: TIMER_W];
   end

   spt_counters #(
      .NPROC   (NPROC),
      .TIMER_W (TIMER_W)
   ) u_counters (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (cnt_adv_i),
      .cnt_o (cnt)
   );

   spt_victim #(
      .DEPTH (DEPTH),
      .AGE_W (AGE_W)
   ) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (inv_valid_i),
      .valid_i (valid_v),
      .hit_i   (hit_v),
      .age_i   (age_arr),
      .sel_o   (sel)
   );

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic wr_en;
      assign wr_en = inv_valid_i && (sel == IDX_W'(g));

      spt_entry #(
         .ADDR_W   (ADDR_W),
         .TIMER_W  (TIMER_W),
         .NPROC    (NPROC),
         .LIFETIME (LIFETIME),
         .AGE_W    (AGE_W)
      ) u_entry (
         .clk         (clk),
         .rst_n       (rst_n),
         .cnt_i       (cnt),
         .obs_valid_i (obs_valid_i),
         .obs_i       (obs_arr),
         .alloc_i     (inv_valid_i),
         .wr_en_i     (wr_en),
         .wr_addr_i   (inv_addr_i),
         .wr_proc_i   (inv_proc_i),
         .wr_timer_i  (inv_probe_i),
         .lk_addr_i   (lk_addr_i),
         .valid_o     (valid_v[g]),
         .inv_hit_o   (hit_v[g]),
         .lk_hit_o    (lkhit_v[g]),
         .usable_o    (use_v[g]),
         .age_o       (age_arr[g])
      );
   end

   assign lk_usable_o = |use_v;

   // R8: one line never occupies two slots
   p_unique_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lkhit_v) && $onehot0(hit_v));

   // R3: without a matching entry the stale copy is never offered
   p_nohit_unusable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(|lkhit_v) |-> !lk_usable_o);

   // R11: the slot written this cycle is valid next cycle whatever else happened
   p_new_entry_survives_r11: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid_i |=> valid_v[$past(sel)]);

endmodule

// File: tb/test_stale_probe_table.sv
`timescale 1ns/1ps
module test_stale_probe_table;

   localparam int NP    = 2;
   localparam int TW    = 5;
   localparam int LT    = 6;
   localparam int D     = 4;
   localparam int AW    = 4;
   localparam int AGW   = $clog2(D) + 1;
   localparam int AGMAX = (1 << AGW) - 1;
   localparam int MASK  = (1 << TW) - 1;
   localparam int HALF  = 1 << (TW - 1);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n;
   logic [NP-1:0]     cnt_adv;
   logic              inv_valid;
   logic [AW-1:0]     inv_addr;
   logic              inv_proc;
   logic [TW-1:0]     inv_probe;
   logic              obs_valid;
   logic [TW-1:0]     obs_tm [NP];
   logic [NP*TW-1:0]  obs_probes;
   logic [AW-1:0]     lk_addr;
   logic              lk_usable;

   always_comb begin
      for (int k = 0; k < NP; k++) obs_probes[k*TW +: TW] = obs_tm[k];
   end

   stale_probe_table #(
      .NPROC(NP), .TIMER_W(TW), .LIFETIME(LT), .DEPTH(D), .ADDR_W(AW)
   ) i_stale_probe_table (
      .clk(clk), .rst_n(rst_n), .cnt_adv_i(cnt_adv),
      .inv_valid_i(inv_valid), .inv_addr_i(inv_addr), .inv_proc_i(inv_proc),
      .inv_probe_i(inv_probe), .obs_valid_i(obs_valid), .obs_probes_i(obs_probes),
      .lk_addr_i(lk_addr), .lk_usable_o(lk_usable)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string tag = "R1";

   // Arithmetic model of the table
   int m_v[D], m_a[D], m_p[D], m_t[D], m_age[D];
   int m_cnt[NP];
   int seed = 32'h1234_5678;

   function automatic int rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      return seed & 32'h7fff_ffff;
   endfunction

   function automatic bit m_usable(int a);
      for (int i = 0; i < D; i++)
         if (m_v[i] != 0 && m_a[i] == a && ((m_cnt[m_p[i]] - m_t[i]) & MASK) < LT)
            return 1'b1;
      return 1'b0;
   endfunction

   task automatic check_all();
      for (int a = 0; a < (1 << AW); a++) begin
         bit exp;
         lk_addr = AW'(a);
         #0.1;
         exp = m_usable(a);
         n_vec++;
         if (lk_usable !== exp) begin
            n_bad++;
            $display("FAIL %s addr %0d: lk_usable=%b expected %b", tag, a, lk_usable, exp);
         end
      end
   endtask

   task automatic model_step();
      int tgt = -1;
      if (inv_valid) begin
         for (int i = 0; i < D; i++)
            if (tgt < 0 && m_v[i] != 0 && m_a[i] == int'(inv_addr)) tgt = i;
         for (int i = 0; i < D; i++)
            if (tgt < 0 && m_v[i] == 0) tgt = i;
         if (tgt < 0) begin
            tgt = 0;
            for (int i = 1; i < D; i++) if (m_age[i] > m_age[tgt]) tgt = i;
         end
      end
      for (int i = 0; i < D; i++) begin
         if (inv_valid && i == tgt) begin
            m_v[i] = 1; m_a[i] = int'(inv_addr); m_p[i] = int'(inv_proc);
            m_t[i] = int'(inv_probe); m_age[i] = 0;
         end else if (m_v[i] != 0) begin
            bit ex, ro;
            ex = ((m_cnt[m_p[i]] - m_t[i]) & MASK) >= LT;
            ro = obs_valid && (((int'(obs_tm[m_p[i]]) - m_t[i]) & MASK) < HALF);
            if (ex || ro) m_v[i] = 0;
            else if (inv_valid && m_age[i] < AGMAX) m_age[i]++;
         end
      end
      for (int k = 0; k < NP; k++) if (cnt_adv[k]) m_cnt[k] = (m_cnt[k] + 1) & MASK;
   endtask

   task automatic idle();
      cnt_adv = '0; inv_valid = 1'b0; inv_addr = '0; inv_proc = 1'b0;
      inv_probe = '0; obs_valid = 1'b0;
      for (int k = 0; k < NP; k++) obs_tm[k] = '0;
   endtask

   task automatic cycle();
      check_all();
      model_step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic inv(int a, int p, int t);
      inv_valid = 1'b1; inv_addr = AW'(a); inv_proc = p[0]; inv_probe = TW'(t & MASK);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(5.0 * 60000);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end

   initial begin
      idle();
      lk_addr = '0;
      rst_n = 1'b0;
      for (int i = 0; i < D; i++) begin m_v[i] = 0; m_a[i] = 0; m_p[i] = 0; m_t[i] = 0; m_age[i] = 0; end
      for (int k = 0; k < NP; k++) m_cnt[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: empty table after reset
      tag = "R1"; check_all(); cycle();

      // R2: invalidation makes the line readable as stale
      tag = "R2"; inv(3, 0, 0); cycle(); cycle();

      // R3: other addresses stay unusable
      tag = "R3"; cycle();

      // R4: expiry at the lifetime, then a full counter wrap
      tag = "R4";
      repeat (8) begin cnt_adv = 2'b01; cycle(); end
      repeat (30) begin cnt_adv = 2'b01; cycle(); end

      // R5: ageing follows only the issuing processor's counter
      tag = "R5"; inv(5, 1, m_cnt[1]); cycle();
      repeat (10) begin cnt_adv = 2'b01; cycle(); end
      repeat (7) begin cnt_adv = 2'b10; cycle(); end

      // R6: re-observation at or after the stored probe frees the entry
      tag = "R6"; inv(7, 0, m_cnt[0]); cycle();
      obs_valid = 1'b1; obs_tm[0] = TW'((m_cnt[0] + 2) & MASK);
      obs_tm[1] = TW'((m_cnt[1] + HALF) & MASK); cycle(); cycle();

      // R7: an observed timer behind the probe does not free it
      tag = "R7"; inv(8, 1, m_cnt[1]); cycle();
      obs_valid = 1'b1; obs_tm[1] = TW'((m_cnt[1] - 3) & MASK);
      obs_tm[0] = TW'((m_cnt[0] - 1) & MASK); cycle(); cycle();

      // R8: same address overwritten in place, now ages on processor 0
      tag = "R8"; inv(8, 0, m_cnt[0]); cycle();
      repeat (7) begin cnt_adv = 2'b10; cycle(); end

      // R10: fill the free slots, nothing displaced
      tag = "R10";
      inv(1, 0, m_cnt[0]); cycle();
      inv(2, 0, m_cnt[0]); cycle();
      inv(4, 0, m_cnt[0]); cycle();

      // R9: full table evicts the oldest entry, then the next oldest
      tag = "R9";
      inv(9, 0, m_cnt[0]); cycle();
      inv(10, 0, m_cnt[0]); cycle();

      // R11: observation covering every entry arrives with a new invalidation
      tag = "R11";
      inv(11, 0, m_cnt[0]); obs_valid = 1'b1; obs_tm[0] = TW'(m_cnt[0]);
      obs_tm[1] = TW'(m_cnt[1]); cycle(); cycle();

      // R11: long mixed traffic against the model
      for (int n = 0; n < 1500; n++) begin
         if (rnd() % 2 == 0) begin
            int p;
            p = rnd() % 2;
            inv(rnd() % 10, p, m_cnt[p] - (rnd() % 8) + 1);
         end
         if (rnd() % 6 == 0) begin
            obs_valid = 1'b1;
            for (int k = 0; k < NP; k++) obs_tm[k] = TW'((m_cnt[k] - (rnd() % 12)) & MASK);
         end
         cnt_adv = NP'(rnd());
         cycle();
      end

      summary();
      $finish;
   end

endmodule